// File: doc/BRIEF.md
# Dual-Cluster Power Controller Register Block

This block is the register side of a power controller that serves two processor clusters, a "big" one and a "little" one. Software uses a simple 32-bit register bus. Through it, software sets a performance level for each cluster and issues configuration reads to a remote configuration space. It also arms wake-up sources, enables cluster powerdown, parks per-CPU resume addresses and samples which CPUs are waiting for interrupt.

Two kinds of write start an operation: a write to a cluster's performance level, and a command write with the start flag set. The actuation behind the operation is modelled by a fixed latency in clock cycles. Each request type then reports its result in its own 4-bit slice of a sticky status word, and a level interrupt stays high while any status bit is pending. A read of the status word returns the pending bits and clears them.

The voltage and clock actuation are not part of the block. The remote configuration bus is replaced by a stub that computes its data from the requested word offset.

Top module: `pwrctl_regs`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is low, `wake_mask_o` is 0 and both powerdown outputs are low.
- R2: An idle write to the big-cluster level register (0x00) or the little-cluster level register (0x08) stores bits [LVL_W-1:0] and starts a request of type 0 or type 1. If the level is below NUM_LEVELS, status bit 4·type is set exactly LATENCY cycles after the write edge, and `irq_o` rises at the same edge.
- R3: A level at or above NUM_LEVELS sets status bit 4·type+1 (the error bit) instead of the completion bit.
- R4: An idle write to the command register (0x10) with bit 31 set starts a type-2 request. Bits [23:20] carry the function code and bits [19:0] the word offset. For function CFG_FUNC (6), the request completes with status bit 8, and the read-data register (0x74) becomes {off[15:0], ~off[15:0]}.
- R5: A command with any other function code sets status bit 9, and it leaves 0x74 unchanged.
- R6: A command write with bit 31 clear is stored and reads back, but it starts no request.
- R7: A read of the status register (0x18) returns the pending bits and clears them. `irq_o` is low after that edge unless a new result posts in the same cycle.
- R8: While a request is pending, writes to 0x00, 0x08 and 0x10 are ignored: neither the stored value nor the status word changes.
- R9: The wake mask (0x24) stores bits [11:0] and drives `wake_mask_o`. Bits 0–3 are the big-cluster per-CPU enables, bits 4 and up are the little-cluster enables, and bits 10–11 are the global enables.
- R10: Bit 0 of 0x30 drives `pd_big_o` and bit 0 of 0x34 drives `pd_little_o`. Both read back as that bit.
- R11: The resume address of big CPU n is at 0x68+4n and that of little CPU n is at 0x78+4n. Each is a read/write 32-bit word.
- R12: 0x3C reads `wfi_i` zero-extended, with big CPU n at bit n and little CPU n at bit 3+n. Writes to 0x3C are ignored, and unmapped addresses read 0.
- R13: A read drives `bus_rvalid_o` high for one cycle after the read edge, with the data registered. A write never raises `bus_rvalid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read |
| wfi_i | input | 3+NUM_LIT | Per-CPU wait-for-interrupt flags |
| irq_o | output | 1 | Level interrupt, high while any status bit is pending |
| wake_mask_o | output | 12 | Wake-up enable mask |
| pd_big_o | output | 1 | Big-cluster powerdown enable |
| pd_little_o | output | 1 | Little-cluster powerdown enable |

## Verification
The assertions assume that the bus strobe is high for single cycles only, and that it is low whenever reset is asserted. They also assume the address is word-aligned. The stimulus drives every access for exactly one cycle between falling edges and uses only aligned addresses. It holds the bus idle during reset, and it waits out the full latency before it reads the status word. The one exception is the busy-write test, which issues its second write one cycle after the first, on purpose.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;

    typedef enum logic [1:0] {
        REQ_BIG = 2'd0,
        REQ_LIT = 2'd1,
        REQ_CFG = 2'd2
    } req_type_e;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_PERF_BIG,
        SEL_PERF_LIT,
        SEL_CMD,
        SEL_STATUS,
        SEL_WAKE,
        SEL_PD_BIG,
        SEL_PD_LIT,
        SEL_WFI,
        SEL_CFGDATA,
        SEL_RES_BIG,
        SEL_RES_LIT
    } reg_sel_e;

    localparam int unsigned OFF_PERF_BIG = 32'h00;
    localparam int unsigned OFF_PERF_LIT = 32'h08;
    localparam int unsigned OFF_CMD      = 32'h10;
    localparam int unsigned OFF_STATUS   = 32'h18;
    localparam int unsigned OFF_WAKE     = 32'h24;
    localparam int unsigned OFF_PD_BIG   = 32'h30;
    localparam int unsigned OFF_PD_LIT   = 32'h34;
    localparam int unsigned OFF_WFI      = 32'h3C;
    localparam int unsigned OFF_RES_BIG  = 32'h68;
    localparam int unsigned OFF_CFGDATA  = 32'h74;
    localparam int unsigned OFF_RES_LIT  = 32'h78;

    localparam int unsigned CMD_GO_BIT = 31;
    localparam int unsigned FUNC_LSB   = 20;
    localparam int unsigned FUNC_W     = 4;
    localparam int unsigned WOFF_W     = 20;
    localparam int unsigned STATUS_W   = 12;
    localparam int unsigned WAKE_W     = 12;
    localparam int unsigned IDX_W      = 2;

endpackage

// File: rtl/pwrctl_regdec.sv
module pwrctl_regdec
    import pwrctl_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned NUM_BIG = 2,
    parameter int unsigned NUM_LIT = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o,
    output logic [IDX_W-1:0]  idx_o
);

    logic [ADDR_W-1:0] rel_big;
    logic [ADDR_W-1:0] rel_lit;

    always_comb begin
        sel_o   = SEL_NONE;
        idx_o   = '0;
        rel_big = addr_i - ADDR_W'(OFF_RES_BIG);
        rel_lit = addr_i - ADDR_W'(OFF_RES_LIT);
        if (addr_i == ADDR_W'(OFF_PERF_BIG))      sel_o = SEL_PERF_BIG;
        else if (addr_i == ADDR_W'(OFF_PERF_LIT)) sel_o = SEL_PERF_LIT;
        else if (addr_i == ADDR_W'(OFF_CMD))      sel_o = SEL_CMD;
        else if (addr_i == ADDR_W'(OFF_STATUS))   sel_o = SEL_STATUS;
        else if (addr_i == ADDR_W'(OFF_WAKE))     sel_o = SEL_WAKE;
        else if (addr_i == ADDR_W'(OFF_PD_BIG))   sel_o = SEL_PD_BIG;
        else if (addr_i == ADDR_W'(OFF_PD_LIT))   sel_o = SEL_PD_LIT;
        else if (addr_i == ADDR_W'(OFF_WFI))      sel_o = SEL_WFI;
        else if (addr_i == ADDR_W'(OFF_CFGDATA))  sel_o = SEL_CFGDATA;
        else if (addr_i >= ADDR_W'(OFF_RES_BIG) && rel_big[1:0] == 2'b00 &&
                 rel_big[ADDR_W-1:2] < (ADDR_W-2)'(NUM_BIG)) begin
            sel_o = SEL_RES_BIG;
            idx_o = rel_big[IDX_W+1:2];
        end
        else if (addr_i >= ADDR_W'(OFF_RES_LIT) && rel_lit[1:0] == 2'b00 &&
                 rel_lit[ADDR_W-1:2] < (ADDR_W-2)'(NUM_LIT)) begin
            sel_o = SEL_RES_LIT;
            idx_o = rel_lit[IDX_W+1:2];
        end
    end

endmodule

// File: rtl/pwrctl_cfgstub.sv
module pwrctl_cfgstub
    import pwrctl_pkg::*;
#(
    parameter int unsigned CFG_FUNC = 6
) (
    input  logic [FUNC_W-1:0] func_i,
    input  logic [15:0]       woff_i,
    output logic              known_o,
    output logic [31:0]       data_o
);

    // Stand-in for the remote configuration space: data derived from offset.
    always_comb begin
        known_o = (func_i == FUNC_W'(CFG_FUNC));
        data_o  = {woff_i, ~woff_i};
    end

endmodule

// File: rtl/pwrctl_opengine.sv
module pwrctl_opengine
    import pwrctl_pkg::*;
#(
    parameter int unsigned LATENCY = 4000
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        start_i,
    input  req_type_e   type_i,
    input  logic        err_i,
    input  logic [31:0] data_i,
    output logic        busy_o,
    output logic        done_o,
    output req_type_e   done_type_o,
    output logic        done_err_o,
    output logic [31:0] done_data_o
);

    localparam int unsigned LAT_W = $clog2(LATENCY + 1);

    typedef struct packed {
        logic             busy;
        logic [LAT_W-1:0] cnt;
        req_type_e        rtype;
        logic             err;
        logic [31:0]      data;
    } eng_s;

    eng_s e_d, e_q;

    always_comb begin
        e_d    = e_q;
        done_o = e_q.busy && (e_q.cnt == LAT_W'(1));
        if (e_q.busy) begin
            e_d.cnt = e_q.cnt - LAT_W'(1);
            if (done_o) e_d.busy = 1'b0;
        end else if (start_i) begin
            e_d.busy  = 1'b1;
            e_d.cnt   = LAT_W'(LATENCY);
            e_d.rtype = type_i;
            e_d.err   = err_i;
            e_d.data  = data_i;
        end
        busy_o      = e_q.busy;
        done_type_o = e_q.rtype;
        done_err_o  = e_q.err;
        done_data_o = e_q.data;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) e_q <= '{busy: 1'b0, cnt: '0, rtype: REQ_BIG, err: 1'b0, data: '0};
        else         e_q <= e_d;
    end

endmodule

// File: rtl/pwrctl_regs.sv
module pwrctl_regs
    import pwrctl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NUM_BIG    = 2,
    parameter int unsigned NUM_LIT    = 3,
    parameter int unsigned LVL_W      = 4,
    parameter int unsigned NUM_LEVELS = 8,
    parameter int unsigned LATENCY    = 4000,
    parameter int unsigned CFG_FUNC   = 6
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 bus_sel_i,
    input  logic                 bus_we_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [31:0]          bus_wdata_i,
    output logic [31:0]          bus_rdata_o,
    output logic                 bus_rvalid_o,
    input  logic [3+NUM_LIT-1:0] wfi_i,
    output logic                 irq_o,
    output logic [WAKE_W-1:0]    wake_mask_o,
    output logic                 pd_big_o,
    output logic                 pd_little_o
);

    localparam int unsigned WFI_W = 3 + NUM_LIT;

    typedef struct packed {
        logic [LVL_W-1:0]          perf_big;
        logic [LVL_W-1:0]          perf_lit;
        logic [31:0]               cmd;
        logic [STATUS_W-1:0]       status;
        logic [WAKE_W-1:0]         wake;
        logic                      pd_big;
        logic                      pd_lit;
        logic [31:0]               cfgdata;
        logic [NUM_BIG-1:0][31:0]  res_big;
        logic [NUM_LIT-1:0][31:0]  res_lit;
        logic [31:0]               rdata;
        logic                      rvalid;
    } regs_s;

    regs_s r_d, r_q;

    reg_sel_e         dec_sel;
    logic [IDX_W-1:0] dec_idx;

    logic        stub_known;
    logic [31:0] stub_data;

    logic        eng_start;
    req_type_e   eng_type;
    logic        eng_err;
    logic [31:0] eng_data;
    logic        eng_busy;
    logic        eng_done;
    req_type_e   eng_done_type;
    logic        eng_done_err;
    logic [31:0] eng_done_data;

    logic [3:0]  post_pos;
    logic        wr_en;
    logic        rd_en;

    pwrctl_regdec #(
        .ADDR_W (ADDR_W),
        .NUM_BIG(NUM_BIG),
        .NUM_LIT(NUM_LIT)
    ) u_dec (
        .addr_i(bus_addr_i),
        .sel_o (dec_sel),
        .idx_o (dec_idx)
    );

    pwrctl_cfgstub #(
        .CFG_FUNC(CFG_FUNC)
    ) u_stub (
        .func_i (bus_wdata_i[FUNC_LSB +: FUNC_W]),
        .woff_i (bus_wdata_i[15:0]),
        .known_o(stub_known),
        .data_o (stub_data)
    );

    pwrctl_opengine #(
        .LATENCY(LATENCY)
    ) u_eng (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (eng_start),
        .type_i     (eng_type),
        .err_i      (eng_err),
        .data_i     (eng_data),
        .busy_o     (eng_busy),
        .done_o     (eng_done),
        .done_type_o(eng_done_type),
        .done_err_o (eng_done_err),
        .done_data_o(eng_done_data)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rvalid = 1'b0;
        wr_en     = bus_sel_i && bus_we_i;
        rd_en     = bus_sel_i && !bus_we_i;
        eng_start = 1'b0;
        eng_type  = REQ_BIG;
        eng_err   = 1'b0;
        eng_data  = '0;
        post_pos  = {eng_done_type, 2'b00} + {3'b000, eng_done_err};

        if (wr_en) begin
            case (dec_sel)
                SEL_PERF_BIG: if (!eng_busy) begin
                    r_d.perf_big = bus_wdata_i[LVL_W-1:0];
                    eng_start    = 1'b1;
                    eng_type     = REQ_BIG;
                    eng_err      = 32'(bus_wdata_i[LVL_W-1:0]) >= 32'(NUM_LEVELS);
                end
                SEL_PERF_LIT: if (!eng_busy) begin
                    r_d.perf_lit = bus_wdata_i[LVL_W-1:0];
                    eng_start    = 1'b1;
                    eng_type     = REQ_LIT;
                    eng_err      = 32'(bus_wdata_i[LVL_W-1:0]) >= 32'(NUM_LEVELS);
                end
                SEL_CMD: if (!eng_busy) begin
                    r_d.cmd   = bus_wdata_i;
                    eng_start = bus_wdata_i[CMD_GO_BIT];
                    eng_type  = REQ_CFG;
                    eng_err   = !stub_known;
                    eng_data  = stub_data;
                end
                SEL_WAKE:   r_d.wake   = bus_wdata_i[WAKE_W-1:0];
                SEL_PD_BIG: r_d.pd_big = bus_wdata_i[0];
                SEL_PD_LIT: r_d.pd_lit = bus_wdata_i[0];
                SEL_RES_BIG: begin
                    for (int i = 0; i < NUM_BIG; i++)
                        if (dec_idx == IDX_W'(i)) r_d.res_big[i] = bus_wdata_i;
                end
                SEL_RES_LIT: begin
                    for (int i = 0; i < NUM_LIT; i++)
                        if (dec_idx == IDX_W'(i)) r_d.res_lit[i] = bus_wdata_i;
                end
                default: ;
            endcase
        end

        if (rd_en) begin
            r_d.rvalid = 1'b1;
            r_d.rdata  = '0;
            case (dec_sel)
                SEL_PERF_BIG: r_d.rdata = 32'(r_q.perf_big);
                SEL_PERF_LIT: r_d.rdata = 32'(r_q.perf_lit);
                SEL_CMD:      r_d.rdata = r_q.cmd;
                SEL_STATUS: begin
                    r_d.rdata  = 32'(r_q.status);
                    r_d.status = '0;
                end
                SEL_WAKE:     r_d.rdata = 32'(r_q.wake);
                SEL_PD_BIG:   r_d.rdata = 32'(r_q.pd_big);
                SEL_PD_LIT:   r_d.rdata = 32'(r_q.pd_lit);
                SEL_WFI:      r_d.rdata = 32'(wfi_i);
                SEL_CFGDATA:  r_d.rdata = r_q.cfgdata;
                SEL_RES_BIG: begin
                    for (int i = 0; i < NUM_BIG; i++)
                        if (dec_idx == IDX_W'(i)) r_d.rdata = r_q.res_big[i];
                end
                SEL_RES_LIT: begin
                    for (int i = 0; i < NUM_LIT; i++)
                        if (dec_idx == IDX_W'(i)) r_d.rdata = r_q.res_lit[i];
                end
                default: ;
            endcase
        end

        // A result posted in the same cycle as a status read survives the clear.
        if (eng_done) begin
            for (int i = 0; i < STATUS_W; i++)
                if (post_pos == 4'(i)) r_d.status[i] = 1'b1;
            if (eng_done_type == REQ_CFG && !eng_done_err)
                r_d.cfgdata = eng_done_data;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign bus_rdata_o  = r_q.rdata;
    assign bus_rvalid_o = r_q.rvalid;
    assign irq_o        = |r_q.status;
    assign wake_mask_o  = r_q.wake;
    assign pd_big_o     = r_q.pd_big;
    assign pd_little_o  = r_q.pd_lit;

    logic unused_wfi_w;
    assign unused_wfi_w = (WFI_W == 0);

endmodule

// File: rtl/pwrctl_regs_chk.sv
module pwrctl_regs_chk
    import pwrctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_sel_i,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_rvalid_o,
    input logic              irq_o,
    input logic              eng_done_i,
    input logic              pd_big_o,
    input logic [WAKE_W-1:0] wake_mask_o
);

    assert_read_gives_valid_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && !bus_we_i) |=> bus_rvalid_o);

    assert_no_valid_without_read_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_sel_i && !bus_we_i) |=> !bus_rvalid_o);

    assert_result_raises_irq_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eng_done_i |=> irq_o);

    assert_irq_rises_only_on_result_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(eng_done_i));

    assert_status_read_clears_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && !bus_we_i && bus_addr_i == ADDR_W'(OFF_STATUS) && !eng_done_i) |=> !irq_o);

    assert_pd_holds_without_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_sel_i && bus_we_i && bus_addr_i == ADDR_W'(OFF_PD_BIG)) |=> $stable(pd_big_o));

    assert_wake_holds_without_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_sel_i && bus_we_i && bus_addr_i == ADDR_W'(OFF_WAKE)) |=> $stable(wake_mask_o));

endmodule

bind pwrctl_regs pwrctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_sel_i   (bus_sel_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rvalid_o(bus_rvalid_o),
    .irq_o       (irq_o),
    .eng_done_i  (eng_done),
    .pd_big_o    (pd_big_o),
    .wake_mask_o (wake_mask_o)
);

// File: tb/pwrctl_regs_bench.sv
module pwrctl_regs_bench;

    localparam int LAT     = 20;
    localparam int NUM_LIT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;
    logic [5:0]  wfi = '0;
    logic        irq;
    logic [11:0] wake;
    logic        pd_big;
    logic        pd_lit;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    pwrctl_regs #(.LATENCY(LAT), .NUM_LIT(NUM_LIT)) u_pwrctl_regs (
        .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .bus_rvalid_o(rvalid), .wfi_i(wfi), .irq_o(irq), .wake_mask_o(wake),
        .pd_big_o(pd_big), .pd_little_o(pd_lit)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected read result when data comes back.
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
                check("R13 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, rdata, e);
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        sel = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", 32'(irq), 32'd0);
        check("R1 wake after reset", 32'(wake), 32'd0);
        check("R1 pd after reset", {30'd0, pd_big, pd_lit}, 32'd0);
        check("R13 rvalid idle", 32'(rvalid), 32'd0);
        bus_read(8'h18, 32'h0, "R1 status reset");
        bus_read(8'h00, 32'h0, "R1 big level reset");
        bus_read(8'h74, 32'h0, "R1 cfg data reset");

        // R2: big-cluster level, completion timing
        bus_write(8'h00, 32'd3);
        check("R13 no rvalid after write", 32'(rvalid), 32'd0);
        repeat (LAT - 1) @(negedge clk);
        check("R2 irq not yet", 32'(irq), 32'd0);
        @(negedge clk);
        check("R2 irq at latency", 32'(irq), 32'd1);
        bus_read(8'h00, 32'd3, "R2 big level readback");
        bus_read(8'h18, 32'h1, "R2 big completion bit0");
        check("R7 irq cleared by read", 32'(irq), 32'd0);
        bus_read(8'h18, 32'h0, "R7 status cleared");

        // R2: little-cluster, top valid level
        bus_write(8'h08, 32'd7);
        repeat (LAT) @(negedge clk);
        bus_read(8'h18, 32'h10, "R2 little completion bit4");

        // R3: out-of-range levels
        bus_write(8'h08, 32'd8);
        repeat (LAT) @(negedge clk);
        bus_read(8'h18, 32'h20, "R3 little error bit5");
        bus_write(8'h00, 32'd15);
        repeat (LAT) @(negedge clk);
        bus_read(8'h18, 32'h2, "R3 big error bit1");

        // R4: config read command, function 6, word offset 0x304
        bus_write(8'h10, 32'h8060_0304);
        repeat (LAT) @(negedge clk);
        bus_read(8'h18, 32'h100, "R4 cfg completion bit8");
        bus_read(8'h74, 32'h0304_FCFB, "R4 cfg data");
        bus_read(8'h10, 32'h8060_0304, "R4 command readback");

        // R5: unknown function
        bus_write(8'h10, 32'h80E0_0011);
        repeat (LAT) @(negedge clk);
        bus_read(8'h18, 32'h200, "R5 cfg error bit9");
        bus_read(8'h74, 32'h0304_FCFB, "R5 cfg data unchanged");

        // R6: no start flag
        bus_write(8'h10, 32'h0060_0005);
        repeat (LAT + 2) @(negedge clk);
        check("R6 no irq", 32'(irq), 32'd0);
        bus_read(8'h18, 32'h0, "R6 status empty");
        bus_read(8'h10, 32'h0060_0005, "R6 command stored");

        // R8: write while busy is dropped
        bus_write(8'h00, 32'd1);
        bus_write(8'h08, 32'd2);
        repeat (LAT - 1) @(negedge clk);
        bus_read(8'h18, 32'h1, "R8 only first result");
        bus_read(8'h08, 32'd8, "R8 little level unchanged");
        repeat (LAT + 2) @(negedge clk);
        bus_read(8'h18, 32'h0, "R8 no late result");

        // R9: wake mask
        bus_write(8'h24, 32'hFFFF_FFFF);
        check("R9 wake masked to 12 bits", 32'(wake), 32'hFFF);
        bus_read(8'h24, 32'hFFF, "R9 wake readback");
        bus_write(8'h24, 32'h0000_0C01);
        check("R9 wake global+cpu0", 32'(wake), 32'hC01);

        // R10: powerdown enables
        bus_write(8'h30, 32'd1);
        check("R10 pd big set", {30'd0, pd_big, pd_lit}, 32'd2);
        bus_write(8'h34, 32'd3);
        check("R10 pd little set", 32'(pd_lit), 32'd1);
        bus_read(8'h34, 32'd1, "R10 pd little readback");
        bus_write(8'h30, 32'd0);
        check("R10 pd big clear", 32'(pd_big), 32'd0);

        // R11: resume mailboxes
        bus_write(8'h68, 32'hA000_0000);
        bus_write(8'h6C, 32'hA000_0004);
        for (int i = 0; i < NUM_LIT; i++)
            bus_write(8'h78 + 8'(4 * i), 32'hB000_0000 + 32'(i));
        bus_read(8'h68, 32'hA000_0000, "R11 big cpu0");
        bus_read(8'h6C, 32'hA000_0004, "R11 big cpu1");
        for (int i = 0; i < NUM_LIT; i++)
            bus_read(8'h78 + 8'(4 * i), 32'hB000_0000 + 32'(i), "R11 little cpu");
        bus_read(8'h70, 32'h0, "R12 unmapped reads zero");

        // R12: WFI status
        wfi = 6'b101_010;
        bus_read(8'h3C, 32'h2A, "R12 wfi word");
        bus_write(8'h3C, 32'hFFFF);
        bus_read(8'h3C, 32'h2A, "R12 wfi write ignored");

        repeat (4) @(negedge clk);
        check("R13 scoreboard drained", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule